// File: doc/BRIEF.md
# Redundant-Radix Successive-Approximation Sequencer

This block sequences a successive-approximation conversion against a DAC whose bit weights shrink by about 1.85 per step instead of 2. Each conversion runs a fixed frame of cycles. In each trial cycle the block raises a trial pattern on the DAC word and reads back a single comparator decision. Whenever a decision commits a bit, the block fetches that bit's calibrated weight from a parameter table and adds it into a binary accumulator. The corrected code therefore comes from the accumulator, not from the raw register bits.

The weights add up to a little more than full scale, so inputs up to about 3% above full scale still convert correctly. The carry bit of the accumulator is reported as an overrange flag. The upper trials raise two DAC bits at once: the bit under test and an overlap bit four positions lower. This makes the decisions tolerant of settling and offset errors. A host pulses `start`, waits for `done`, and reads `result` and `ovr`. The auto-zero enable lets the comparator null its offset during the closing cycles of every frame.

Top module: `rsar_seq`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `az_en` and `ovr` are low, and `dac_word` and `result` are zero.
- R2: When `start` is high at a rising edge while idle, a conversion begins. `busy` is then high for exactly 20 consecutive cycles, and `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R3: A `start` pulse while `busy` is high is ignored. The frame length is unchanged and only one result is produced.
- R4: In the first busy cycle, `dac_word` is 0x880 (bits 11 and 7 set, all others clear).
- R5: Busy cycle k (k = 0..11) tests bit 11-k. For k below 8, bit 7-k is raised as well, as an overlap bit. `dac_word` is the set of committed bits plus these trial bits. In busy cycles 12..19 no trial bits are raised.
- R6: The comparator is sampled at the end of each trial cycle. A high decision commits the tested bit, which then stays set in `dac_word`, and adds that bit's weight. A low decision leaves the bit clear. The overlap bit is never committed by a pair trial.
- R7: The 13-bit value {`ovr`,`result`} equals the sum of the weights of the committed bits. `ovr` is the carry into bit 12. The default weights for bits 0..11 are 2, 4, 8, 14, 26, 48, 89, 166, 306, 567, 1048 and 1939, which sum to 4217.
- R8: With an ideal comparator (high when the input is at or above the DAC word's weighted value), every integer input from 0 to 4217 yields {`ovr`,`result`} equal to the input or to one below it.
- R9: `result` and `ovr` load only at the end of busy cycle 16. They keep their value at all other times, including in idle and during the first 17 cycles of the next conversion.
- R10: `az_en` is high in exactly the last 3 busy cycles (17..19). The committed bits and the accumulator clear during these cycles, so `dac_word` is zero from busy cycle 18 onwards and in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_hi | input | 1 | Comparator decision: input at or above DAC level |
| dac_word | output | 12 | Trial word driven to the DAC |
| result | output | 12 | Corrected conversion code |
| ovr | output | 1 | Overrange flag (accumulator carry) |
| busy | output | 1 | Conversion frame in progress |
| done | output | 1 | One-cycle pulse after the frame ends |
| az_en | output | 1 | Comparator auto-zero enable |

## Verification
The bench builds the block with its default geometry: 12 bits, overlap distance 4, a 20-cycle frame with 3 auto-zero cycles, and the default weight table passed in explicitly. Its comparator model turns the DAC word into a weighted level. With these values an exhaustive sweep of every integer input from 0 to 4217 takes under 100k cycles. The sweep therefore covers every decision path, the point where the carry first sets at 4096, and the quantisation loss at the low-weight bits where the redundancy runs out.

// File: rtl/rsar_seq.sv
module rsar_seq #(
  parameter int NB          = 12,
  parameter int OVL         = 4,
  parameter int WW          = 13,
  parameter int CONV_CYCLES = 20,
  parameter int AZ_CYCLES   = 3,
  parameter logic [WW-1:0] WGT [NB-1:0] =
    '{13'd1939, 13'd1048, 13'd567, 13'd306, 13'd166, 13'd89,
      13'd48,   13'd26,   13'd14,  13'd8,   13'd4,   13'd2}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_hi,
  output logic [NB-1:0] dac_word,
  output logic [NB-1:0] result,
  output logic          ovr,
  output logic          busy,
  output logic          done,
  output logic          az_en
);

  localparam int NPAIR = NB - OVL;
  localparam int PW    = $clog2(CONV_CYCLES + 1);
  localparam int BW    = $clog2(NB);
  localparam logic [PW-1:0] PH_LAST  = PW'(CONV_CYCLES - 1);
  localparam logic [PW-1:0] PH_AZ    = PW'(CONV_CYCLES - AZ_CYCLES);
  localparam logic [PW-1:0] PH_LATCH = PW'(CONV_CYCLES - AZ_CYCLES - 1);
  localparam logic [PW-1:0] PH_TEND  = PW'(NB);
  localparam logic [PW-1:0] PH_PEND  = PW'(NPAIR);

  logic [PW-1:0] ph;
  logic          busy_q, done_q, ovr_q;
  logic [NB-1:0] sar, res_q, tmask, hit;
  logic [WW-1:0] acc, wsel;
  logic [BW-1:0] bsel, osel;
  logic          trial, az;

  assign trial = busy_q && (ph < PH_TEND);
  assign az    = busy_q && (ph >= PH_AZ);
  assign bsel  = BW'(NB - 1 - int'(ph));
  assign osel  = BW'(NB - 1 - OVL - int'(ph));

  always_comb begin
    tmask = '0;
    hit   = '0;
    wsel  = '0;
    if (trial) begin
      hit[bsel]   = 1'b1;
      tmask[bsel] = 1'b1;
      if (ph < PH_PEND) tmask[osel] = 1'b1;
      wsel = WGT[bsel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sar    <= '0;
      acc    <= '0;
      res_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          ph     <= '0;
        end
      end else begin
        if (ph == PH_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          ph     <= '0;
        end else begin
          ph <= ph + 1'b1;
        end
        if (trial && cmp_hi) begin
          sar <= sar | hit;
          acc <= acc + wsel;
        end
        if (ph == PH_LATCH) begin
          res_q <= acc[NB-1:0];
          ovr_q <= |acc[WW-1:NB];
        end
        if (az) begin
          sar <= '0;
          acc <= '0;
        end
      end
    end
  end

  assign dac_word = sar | tmask;
  assign result   = res_q;
  assign ovr      = ovr_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign az_en    = az;

  p_done_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_ignore_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && ph != PH_LAST) |=> (busy_q && ph == $past(ph) + 1'b1));

  p_first_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($countones(dac_word) == 2 && dac_word[NB-1] && dac_word[NB-1-OVL]));

  p_trial_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trial |-> ($countones(dac_word & ~sar) == ((ph < PH_PEND) ? 2 : 1)));

  p_sticky_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !az) |=> ((sar & $past(sar)) == $past(sar)));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> ($stable(res_q) && $stable(ovr_q)));

  p_az_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    az |=> (sar == '0 && acc == '0));

endmodule

// File: tb/sim_rsar_seq.sv
module sim_rsar_seq;
  localparam int NB   = 12;
  localparam int OVL  = 4;
  localparam int WW   = 13;
  localparam int CONV = 20;
  localparam int AZC  = 3;
  localparam int VMAX = 4217;
  localparam logic [WW-1:0] W [NB-1:0] =
    '{13'd1939, 13'd1048, 13'd567, 13'd306, 13'd166, 13'd89,
      13'd48,   13'd26,   13'd14,  13'd8,   13'd4,   13'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_hi;
  logic [NB-1:0] dac_word, result;
  logic ovr, busy, done, az_en;

  int vin = 0;
  int checks = 0;
  int errors = 0;
  int nres = 0;
  int nconv = 0;
  int expq[$];
  int vinq[$];

  always #10 clk = ~clk;

  rsar_seq #(.NB(NB), .OVL(OVL), .WW(WW), .CONV_CYCLES(CONV),
             .AZ_CYCLES(AZC), .WGT(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
    .dac_word(dac_word), .result(result), .ovr(ovr),
    .busy(busy), .done(done), .az_en(az_en));

  always_comb begin
    int lvl;
    lvl = 0;
    for (int i = 0; i < NB; i++) if (dac_word[i]) lvl += int'(W[i]);
    cmp_hi = (vin >= lvl);
  end

  function automatic int refconv(input int v);
    int a;
    a = 0;
    for (int k = 0; k < NB; k++) begin
      int b, lvl;
      b = NB - 1 - k;
      lvl = a + int'(W[b]) + ((k < NB - OVL) ? int'(W[b-OVL]) : 0);
      if (v >= lvl) a += int'(W[b]);
    end
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code13();
    return int'({ovr, result});
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R3 unexpected extra result", code13(), -1);
      end else begin
        int e, v;
        e = expq.pop_front();
        v = vinq.pop_front();
        chk(code13() == e, "R7 corrected code", code13(), e);
        chk((v - code13()) == 0 || (v - code13()) == 1, "R8 within one LSB below input", code13(), v);
      end
      nres++;
    end
  end

  task automatic run(input int v, input bit poke);
    int sar_m = 0;
    int acc_m = 0;
    int nb = 0;
    int e, prev;
    bit seq_ok = 1'b1;
    bit az_ok = 1'b1;
    @(negedge clk);
    vin = v;
    start = 1'b1;
    e = refconv(v);
    expq.push_back(e);
    vinq.push_back(v);
    nconv++;
    prev = code13();
    @(negedge clk);
    start = 1'b0;
    while (busy && nb < CONV + 5) begin
      int mask, b, exp_dac;
      mask = 0;
      b = NB - 1 - nb;
      if (nb < NB) begin
        mask = 1 << b;
        if (nb < NB - OVL) mask |= 1 << (b - OVL);
      end
      exp_dac = (nb > CONV - AZC) ? 0 : (sar_m | mask);
      if (int'(dac_word) != exp_dac) seq_ok = 1'b0;
      if (nb == 0) chk(dac_word == 12'h880, "R4 first pair trial", int'(dac_word), 'h880);
      if (nb < NB) begin
        if (v >= acc_m + int'(W[b]) + ((nb < NB - OVL) ? int'(W[b-OVL]) : 0)) begin
          sar_m |= 1 << b;
          acc_m += int'(W[b]);
        end
      end
      if (az_en != (nb >= CONV - AZC)) az_ok = 1'b0;
      if (nb == CONV - AZC - 1) chk(code13() == prev, "R9 held before latch", code13(), prev);
      if (nb == CONV - AZC) chk(code13() == e, "R9 loaded at latch", code13(), e);
      if (poke && nb == 5) start = 1'b1;
      if (poke && nb == 6) start = 1'b0;
      nb++;
      @(negedge clk);
    end
    chk(nb == CONV, "R2 busy length", nb, CONV);
    chk(seq_ok, "R5 R6 trial and commit sequence", int'(seq_ok), 1);
    chk(az_ok, "R10 auto-zero window", int'(az_ok), 1);
    chk(done == 1'b1, "R2 done after frame", int'(done), 1);
    chk(dac_word == '0, "R10 cleared in idle", int'(dac_word), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !az_en && !ovr, "R1 reset flags", int'({busy, done, az_en, ovr}), 0);
    chk(dac_word == '0 && result == '0, "R1 reset words", int'({dac_word, result}), 0);
    rst_n = 1'b1;
    run(0, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", int'(done), 0);
    run(VMAX, 1'b0);
    chk(ovr == 1'b1, "R7 overrange at top", int'(ovr), 1);
    run(4095, 1'b0);
    chk(ovr == 1'b0, "R7 no overrange at full scale", int'(ovr), 0);
    run(4100, 1'b0);
    chk(ovr == 1'b1, "R7 overrange above full scale", int'(ovr), 1);
    begin
      int held;
      held = code13();
      repeat (6) @(negedge clk);
      chk(code13() == held, "R9 stable while idle", code13(), held);
    end
    run(1234, 1'b1);
    repeat (3) @(negedge clk);
    chk(nres == nconv, "R3 one result per accepted start", nres, nconv);
    for (int v = 0; v <= VMAX; v++) run(v, 1'b0);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0 && nres == nconv, "R2 every conversion completed", nres, nconv);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", nres, nconv);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule